// File: doc/BRIEF.md
# Latched Interrupt Status Mask Unit

This block collects interrupt causes for the host side of a network controller and drives one hardware interrupt line. Pulses and levels from the receiver, the transmitter, the buffer allocator and the protocol engine arrive as plain inputs. Three of the causes are latched until the host clears them by writing a one to an acknowledge port. One cause mirrors the most recent allocation result. One summary cause merges several exception conditions, each of which can be switched off by an enable bit.

A 16-bit mask register decides which status bits may raise the interrupt. The host can write it as a whole word or one byte at a time. The interrupt output is a registered level, so it follows any change in status or mask one clock later. The counters, the FIFOs and the control register that holds the exception enables live outside this block and appear only as input signals.

Status bit positions, used by the mask, the status readback and the acknowledge port: bit 0 transmit-empty, bit 1 allocation-ok, bit 2 receive-overrun, bit 3 receive-discard, bit 4 exception summary.

Top module: `irq_gather`

## Requirements
- R1: After reset, `mask_rdata` is 0, every status bit is 0 (the allocation-ok bit included) and `irq_o` is 0.
- R2: `irq_o` is 1 in the cycle after one in which some `status_o` bit and the mask bit at the same position are both 1. It is 0 in the cycle after one in which no such pair exists.
- R3: In a write cycle, mask byte 0 (bits 7:0) is loaded from `mask_wdata` only when `mask_be[0]` is 1, and byte 1 (bits 15:8) only when `mask_be[1]` is 1. A byte whose enable is 0 keeps its value.
- R4: Receive-discard (bit 3) is set when `disc_inc` is 1 and `disc_cnt` holds 0xFF. An increment to any other value, or the value 0xFF without `disc_inc`, does not set it.
- R5: Receive-overrun (bit 2) is set when any one of `rx_abort_nobuf`, `rx_abort_long` or `rx_abort_drop` is 1.
- R6: Allocation-ok (bit 1) equals the inverse of `alloc_failed` as sampled in the last cycle in which `alloc_done` was 1. It is not latched and does not change between results.
- R7: Transmit-empty (bit 0) is set in every cycle in which `txq_empty` is 1. Once set, it stays set after `txq_empty` falls, until it is acknowledged.
- R8: The exception summary (bit 4) is the OR of `exc_link & exc_en[0]`, `exc_roll & exc_en[1]`, and the OR of the five `fatal_cause` bits gated by `exc_en[2]`.
- R9: With `ack_we` at 1, each latched bit (0, 2, 3) whose `ack_wdata` bit is 1 is cleared. Latched bits written as 0 keep their value. Bits 1 and 4 are not affected.
- R10: If a set condition and an acknowledge for the same latched bit arrive in the same cycle, the bit is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wdata | input | 16 | Mask write data |
| mask_be | input | 2 | Mask byte write enables |
| mask_rdata | output | 16 | Mask register contents |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_wdata | input | 5 | Acknowledge data, a 1 clears the latched bit |
| status_o | output | 5 | Interrupt status bits |
| irq_o | output | 1 | Registered interrupt request |
| disc_inc | input | 1 | Discard counter incremented this cycle |
| disc_cnt | input | 8 | Discard counter value after the increment |
| rx_abort_nobuf | input | 1 | Receive aborted, buffer allocation failed |
| rx_abort_long | input | 1 | Receive aborted, frame over 2048 bytes |
| rx_abort_drop | input | 1 | Receive aborted, discard control set |
| alloc_done | input | 1 | Allocation request completed |
| alloc_failed | input | 1 | Allocation result failed flag |
| txq_empty | input | 1 | Transmit FIFO empty level |
| exc_link | input | 1 | Link transition status |
| exc_roll | input | 1 | Statistics counter rollover status |
| fatal_cause | input | 5 | Underrun, SQE error, lost carrier, late collision, 16 collisions |
| exc_en | input | 3 | Exception enables: link, rollover, fatal |

## Verification
The assertions assume that every input is a clean 0 or 1, sampled at the rising edge. They assume the acknowledge strobe and the mask byte enables carry meaning only in the cycle in which they are high, and that `disc_cnt` is valid whenever `disc_inc` is high. The bench changes inputs only on falling edges and drops each event pulse after a single cycle. It keeps all undriven inputs at 0, so every cause it checks is the only one active on its bit. Set and acknowledge are made to meet in one cycle only in the case that tests their priority.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 5;
  localparam int NLAT      = 3;
  localparam int B_TXE     = 0;
  localparam int B_ALLOC   = 1;
  localparam int B_RXOVR   = 2;
  localparam int B_RXDISC  = 3;
  localparam int B_EXC     = 4;
  // Latch bank slot order
  localparam int L_TXE     = 0;
  localparam int L_RXOVR   = 1;
  localparam int L_RXDISC  = 2;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_d, q_r;

  // set dominates clear so that no event is dropped
  always_comb begin
    q_d = set_i | (q_r & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q_o = q_r;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_r[i]); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_r[i]); // R9
    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (q_r[i] && !clr_i[i]) |=> q_r[i]); // R7
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] be,
  output logic [DW-1:0]   q_o
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_d, lane_r;
    logic       lane_en;

    assign lane_en = be[b];

    always_comb begin
      lane_d = lane_r;
      if (lane_en) lane_d = wdata[b*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_r <= '0;
      else if (lane_en) lane_r <= lane_d;
    end

    assign q_o[b*8 +: 8] = lane_r;

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !be[b] |=> $stable(q_o[b*8 +: 8])); // R3
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      be[b] |=> (q_o[b*8 +: 8] == $past(wdata[b*8 +: 8]))); // R3
  end
endmodule

// File: rtl/irq_exc_merge.sv
module irq_exc_merge #(
  parameter int NFATAL = 5
) (
  input  logic              link_i,
  input  logic              roll_i,
  input  logic [NFATAL-1:0] fatal_i,
  input  logic [2:0]        en_i,
  output logic              sum_o
);
  logic fatal_any;
  logic [2:0] gated;

  always_comb begin
    fatal_any = |fatal_i;
    gated[0]  = link_i    & en_i[0];
    gated[1]  = roll_i    & en_i[1];
    gated[2]  = fatal_any & en_i[2];
    sum_o     = |gated;
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int NFATAL = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   mask_wdata,
  input  logic [DATA_W/8-1:0] mask_be,
  output logic [DATA_W-1:0]   mask_rdata,
  input  logic                ack_we,
  input  logic [NSRC-1:0]     ack_wdata,
  output logic [NSRC-1:0]     status_o,
  output logic                irq_o,
  input  logic                disc_inc,
  input  logic [CNT_W-1:0]    disc_cnt,
  input  logic                rx_abort_nobuf,
  input  logic                rx_abort_long,
  input  logic                rx_abort_drop,
  input  logic                alloc_done,
  input  logic                alloc_failed,
  input  logic                txq_empty,
  input  logic                exc_link,
  input  logic                exc_roll,
  input  logic [NFATAL-1:0]   fatal_cause,
  input  logic [2:0]          exc_en
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [NLAT-1:0] lat_set, lat_clr, lat_q;
  logic            exc_sum;
  logic            fail_d, fail_r;
  logic            irq_d, irq_r;
  src_vec_t        stat;

  // latched event sources
  always_comb begin
    lat_set           = '0;
    lat_set[L_TXE]    = txq_empty;
    lat_set[L_RXOVR]  = rx_abort_nobuf | rx_abort_long | rx_abort_drop;
    lat_set[L_RXDISC] = disc_inc & (disc_cnt == CNT_TOP);
    lat_clr           = '0;
    if (ack_we) begin
      lat_clr[L_TXE]    = ack_wdata[B_TXE];
      lat_clr[L_RXOVR]  = ack_wdata[B_RXOVR];
      lat_clr[L_RXDISC] = ack_wdata[B_RXDISC];
    end
  end

  irq_latch_bank #(.N(NLAT)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (lat_set),
    .clr_i (lat_clr),
    .q_o   (lat_q)
  );

  irq_mask_reg #(.DW(DATA_W)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wdata (mask_wdata),
    .be    (mask_be),
    .q_o   (mask_rdata)
  );

  irq_exc_merge #(.NFATAL(NFATAL)) u_exc (
    .link_i  (exc_link),
    .roll_i  (exc_roll),
    .fatal_i (fatal_cause),
    .en_i    (exc_en),
    .sum_o   (exc_sum)
  );

  // allocation result: a level that tracks the latest completion
  always_comb begin
    fail_d = fail_r;
    if (alloc_done) fail_d = alloc_failed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fail_r <= 1'b1;
    else if (alloc_done) fail_r <= fail_d;
  end

  always_comb begin
    stat           = '0;
    stat[B_TXE]    = lat_q[L_TXE];
    stat[B_ALLOC]  = ~fail_r;
    stat[B_RXOVR]  = lat_q[L_RXOVR];
    stat[B_RXDISC] = lat_q[L_RXDISC];
    stat[B_EXC]    = exc_sum;
    irq_d          = |(stat & mask_rdata[NSRC-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= irq_d;
  end

  assign status_o = stat;
  assign irq_o    = irq_r;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_o & mask_rdata[NSRC-1:0])) |=> irq_o); // R2
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_o & mask_rdata[NSRC-1:0])) |=> !irq_o); // R2
  AST_ALLOC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |=> (status_o[B_ALLOC] == !$past(alloc_failed))); // R6
  AST_ALLOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_done |=> $stable(status_o[B_ALLOC])); // R6
  AST_EXC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en == 3'b000) |-> !status_o[B_EXC]); // R8
  AST_DISC_ONLY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o[B_RXDISC] && !(disc_inc && disc_cnt == CNT_TOP)) |=> !status_o[B_RXDISC]); // R4
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_abort_nobuf || rx_abort_long || rx_abort_drop) |=> status_o[B_RXOVR]); // R5
endmodule

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
  logic        clk;
  logic        rst_n;
  logic [15:0] mask_wdata;
  logic [1:0]  mask_be;
  logic [15:0] mask_rdata;
  logic        ack_we;
  logic [4:0]  ack_wdata;
  logic [4:0]  status_o;
  logic        irq_o;
  logic        disc_inc;
  logic [7:0]  disc_cnt;
  logic        rx_abort_nobuf, rx_abort_long, rx_abort_drop;
  logic        alloc_done, alloc_failed;
  logic        txq_empty;
  logic        exc_link, exc_roll;
  logic [4:0]  fatal_cause;
  logic [2:0]  exc_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_gather u0 (
    .clk(clk), .rst_n(rst_n),
    .mask_wdata(mask_wdata), .mask_be(mask_be), .mask_rdata(mask_rdata),
    .ack_we(ack_we), .ack_wdata(ack_wdata),
    .status_o(status_o), .irq_o(irq_o),
    .disc_inc(disc_inc), .disc_cnt(disc_cnt),
    .rx_abort_nobuf(rx_abort_nobuf), .rx_abort_long(rx_abort_long),
    .rx_abort_drop(rx_abort_drop),
    .alloc_done(alloc_done), .alloc_failed(alloc_failed),
    .txq_empty(txq_empty),
    .exc_link(exc_link), .exc_roll(exc_roll),
    .fatal_cause(fatal_cause), .exc_en(exc_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic write_mask(input logic [15:0] d, input logic [1:0] be);
    mask_wdata = d; mask_be = be;
    tick();
    mask_be = 2'b00;
  endtask

  task automatic ack(input logic [4:0] d);
    ack_we = 1'b1; ack_wdata = d;
    tick();
    ack_we = 1'b0; ack_wdata = '0;
  endtask

  task automatic t_reset();
    check("R1 mask after reset", mask_rdata, 16'h0000);
    check("R1 status after reset", status_o, 5'b00000);
    check("R1 irq after reset", irq_o, 1'b0);
  endtask

  task automatic t_mask_bytes();
    write_mask(16'hABCD, 2'b01);
    check("R3 low byte only", mask_rdata, 16'h00CD);
    write_mask(16'h12FF, 2'b10);
    check("R3 high byte only", mask_rdata, 16'h12CD);
    write_mask(16'hFFFF, 2'b00);
    check("R3 no lane enabled", mask_rdata, 16'h12CD);
    write_mask(16'h0000, 2'b11);
    check("R3 full word", mask_rdata, 16'h0000);
  endtask

  task automatic t_discard();
    disc_inc = 1'b1; disc_cnt = 8'hFE;
    tick();
    disc_inc = 1'b0;
    check("R4 increment to 0xFE", status_o[3], 1'b0);
    disc_cnt = 8'hFF;
    tick();
    check("R4 0xFF without increment", status_o[3], 1'b0);
    disc_inc = 1'b1;
    tick();
    disc_inc = 1'b0; disc_cnt = 8'h00;
    check("R4 increment to 0xFF", status_o[3], 1'b1);
    tick();
    check("R2 masked bit gives no irq", irq_o, 1'b0);
    write_mask(16'h0008, 2'b01);
    tick();
    check("R2 irq after unmask", irq_o, 1'b1);
    ack(5'b01000);
    check("R9 discard cleared", status_o[3], 1'b0);
    tick();
    check("R2 irq drops after clear", irq_o, 1'b0);
    write_mask(16'h0000, 2'b11);
  endtask

  task automatic t_overrun();
    for (int k = 0; k < 3; k++) begin
      rx_abort_nobuf = (k == 0); rx_abort_long = (k == 1); rx_abort_drop = (k == 2);
      tick();
      rx_abort_nobuf = 0; rx_abort_long = 0; rx_abort_drop = 0;
      tick();
      check($sformatf("R5 overrun cause %0d", k), status_o[2], 1'b1);
      ack(5'b00100);
      check($sformatf("R9 overrun cleared after cause %0d", k), status_o[2], 1'b0);
    end
  endtask

  task automatic t_alloc();
    alloc_done = 1'b1; alloc_failed = 1'b0;
    tick();
    alloc_done = 1'b0; alloc_failed = 1'b1;
    check("R6 success sets bit", status_o[1], 1'b1);
    tick();
    check("R6 failed flag without done ignored", status_o[1], 1'b1);
    ack(5'b11111);
    check("R9 ack has no effect on alloc bit", status_o[1], 1'b1);
    alloc_done = 1'b1; alloc_failed = 1'b1;
    tick();
    alloc_done = 1'b0; alloc_failed = 1'b0;
    check("R6 failure clears bit", status_o[1], 1'b0);
  endtask

  task automatic t_txempty();
    txq_empty = 1'b1;
    tick();
    check("R7 empty sets bit", status_o[0], 1'b1);
    ack(5'b00001);
    check("R7 live empty re-sets after ack", status_o[0], 1'b1);
    txq_empty = 1'b0;
    tick();
    check("R7 latched after empty falls", status_o[0], 1'b1);
    ack(5'b00001);
    check("R7 clear then read shows not empty", status_o[0], 1'b0);
  endtask

  task automatic t_exception();
    write_mask(16'h0010, 2'b01);
    exc_link = 1'b1; exc_en = 3'b000;
    tick();
    check("R8 link disabled", status_o[4], 1'b0);
    check("R2 no irq from disabled source", irq_o, 1'b0);
    exc_en = 3'b001;
    #1;
    check("R8 link enabled", status_o[4], 1'b1);
    tick();
    check("R2 irq from exception", irq_o, 1'b1);
    ack(5'b10000);
    check("R9 ack leaves exception bit", status_o[4], 1'b1);
    exc_link = 1'b0; exc_roll = 1'b1;
    #1;
    check("R8 rollover not enabled", status_o[4], 1'b0);
    exc_en = 3'b010;
    #1;
    check("R8 rollover enabled", status_o[4], 1'b1);
    exc_roll = 1'b0; exc_en = 3'b100;
    for (int k = 0; k < 5; k++) begin
      fatal_cause = 5'b00001 << k;
      #1;
      check($sformatf("R8 fatal cause %0d", k), status_o[4], 1'b1);
    end
    exc_en = 3'b011;
    #1;
    check("R8 fatal without enable", status_o[4], 1'b0);
    fatal_cause = '0; exc_en = 3'b000;
    write_mask(16'h0000, 2'b11);
  endtask

  task automatic t_selective_ack();
    txq_empty = 1'b1; disc_inc = 1'b1; disc_cnt = 8'hFF;
    tick();
    txq_empty = 1'b0; disc_inc = 1'b0; disc_cnt = 8'h00;
    ack(5'b01000);
    check("R9 only written bit cleared", status_o & 5'b01101, 5'b00001);
    ack(5'b00001);
    check("R9 second ack clears the rest", status_o & 5'b01101, 5'b00000);
  endtask

  task automatic t_collision();
    rx_abort_long = 1'b1; ack_we = 1'b1; ack_wdata = 5'b00100;
    tick();
    rx_abort_long = 1'b0; ack_we = 1'b0; ack_wdata = '0;
    check("R10 event wins over ack", status_o[2], 1'b1);
    ack(5'b00100);
    check("R10 later ack clears", status_o[2], 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    mask_wdata = '0; mask_be = '0; ack_we = 0; ack_wdata = '0;
    disc_inc = 0; disc_cnt = '0;
    rx_abort_nobuf = 0; rx_abort_long = 0; rx_abort_drop = 0;
    alloc_done = 0; alloc_failed = 0; txq_empty = 0;
    exc_link = 0; exc_roll = 0; fatal_cause = '0; exc_en = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mask_bytes();
    t_discard();
    t_overrun();
    t_alloc();
    t_txempty();
    t_exception();
    t_selective_ack();
    t_collision();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule